// File: doc/BRIEF.md
# Stage-Skipping Multi-Cycle Processor Core

This block is a compact 32-bit processor. It spends one clock cycle on each execution stage and visits only the stages that the current instruction needs. The stages always come in the same order: fetch, decode with register read, execute, memory access and register write-back. A small sequencer inside the core looks at the opcode and function fields and jumps past any stage the instruction does not use. A load therefore takes five cycles, ALU and store instructions take four, and a jump takes two.

The core holds its own program counter, a 32-entry register file, an ALU, the holding registers between stages, and two small word arrays for instructions and data. A test environment fills these arrays through load ports while reset is held. It can read any register and any data word combinationally through two peek ports. A one-cycle completion strobe marks the final cycle of every instruction, so cycles per instruction can be counted from outside.

Top module: `stage_skip_cpu`

## Requirements
- R1: Stages advance one per clock, never out of order. Encodings on `stage_out`: 0 fetch, 1 decode, 2 execute, 3 memory, 4 write-back. Every instruction begins with a fetch cycle.
- R2: The fetch cycle latches the instruction word at `pc` and sets `pc` to `pc + 4`. Memory is byte addressed.
- R3: R-type instructions (opcode 0, rs in bits 25:21, rt in 20:16, rd in 15:11) compute rd from rs and rt. The funct field in bits 5:0 selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than.
- R4: Opcode 0x08 adds and opcode 0x0A compares signed. Both use the sign-extended 16-bit immediate and write the result to rt. The compare writes 1 when rs is below the immediate and 0 otherwise.
- R5: Opcode 0x23 loads the data word at rs + sign-extended immediate into rt. It is the only instruction that takes all five cycles.
- R6: Opcode 0x2B stores rt to the data word at rs + sign-extended immediate. It skips write-back, leaves every register unchanged and takes four cycles.
- R7: R-type and immediate ALU instructions skip the memory stage and take four cycles.
- R8: Opcode 0x02 finishes after decode, in two cycles. It sets `pc` to the upper 4 bits of the incremented PC, followed by the 26-bit target, followed by two zero bits.
- R9: Register 0 always reads as zero. Writes to it have no effect.
- R10: `instr_done` is high in exactly the last cycle of each instruction. The next cycle is a fetch.
- R11: Synchronous active-high `rst` clears `pc` and all registers to zero and puts the sequencer in the fetch stage.
- R12: Any other opcode, or an R-type word with another funct value, finishes after decode in two cycles. It changes nothing except `pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_load_en | input | 1 | Write strobe for the instruction array |
| imem_load_idx | input | $clog2(IMEM_WORDS) | Word index for the instruction write |
| imem_load_data | input | 32 | Instruction word to write |
| dmem_load_en | input | 1 | Write strobe for the data array |
| dmem_load_idx | input | $clog2(DMEM_WORDS) | Word index for the data write |
| dmem_load_data | input | 32 | Data word to write |
| rf_peek_addr | input | 5 | Register to observe |
| rf_peek_data | output | 32 | Value of the observed register |
| dm_peek_idx | input | $clog2(DMEM_WORDS) | Data word to observe |
| dm_peek_data | output | 32 | Value of the observed data word |
| pc_out | output | 32 | Current program counter |
| stage_out | output | 3 | Current stage code |
| instr_done | output | 1 | High in the final cycle of an instruction |

## Verification
The bench checks the cycle count of every instruction class against the skip rules. A sequencer that passed through memory on ALU instructions would report five cycles for them, and one that skipped memory on loads would report four for a load. Signed comparisons are run with negative operands, so an unsigned comparator would write the wrong 0 or 1. A load and a store use a negative offset from a base register, so an adder that zero-extends the immediate would miss the word. Further directed cases cover a write aimed at register 0, a jump that steps over instructions that must not run, and an unsupported opcode that must leave every register alone. A long random sequence then compares every register write, every store and the PC against a model in the bench.

// File: rtl/stage_skip_cpu.sv
module stage_skip_cpu #(
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          imem_load_en,
  input  logic [$clog2(IMEM_WORDS)-1:0] imem_load_idx,
  input  logic [31:0]                   imem_load_data,
  input  logic                          dmem_load_en,
  input  logic [$clog2(DMEM_WORDS)-1:0] dmem_load_idx,
  input  logic [31:0]                   dmem_load_data,
  input  logic [4:0]                    rf_peek_addr,
  output logic [31:0]                   rf_peek_data,
  input  logic [$clog2(DMEM_WORDS)-1:0] dm_peek_idx,
  output logic [31:0]                   dm_peek_data,
  output logic [31:0]                   pc_out,
  output logic [2:0]                    stage_out,
  output logic                          instr_done
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  typedef enum logic [2:0] {S_IF = 3'd0, S_ID = 3'd1, S_EX = 3'd2, S_MEM = 3'd3, S_WB = 3'd4} stage_t;

  stage_t      stage;
  logic [31:0] pc, ir, a_q, b_q, alu_q, mdr_q;
  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] rf   [32];

  wire [5:0]  op    = ir[31:26];
  wire [5:0]  funct = ir[5:0];
  wire [4:0]  rs    = ir[25:21];
  wire [4:0]  rt    = ir[20:16];
  wire [4:0]  rd    = ir[15:11];
  wire [31:0] simm  = {{16{ir[15]}}, ir[15:0]};

  wire is_r    = (op == 6'h00) && (funct == 6'h20 || funct == 6'h22 || funct == 6'h24 ||
                                   funct == 6'h25 || funct == 6'h2A);
  wire is_addi = (op == 6'h08);
  wire is_slti = (op == 6'h0A);
  wire is_lw   = (op == 6'h23);
  wire is_sw   = (op == 6'h2B);
  wire is_j    = (op == 6'h02);
  wire legal   = is_r | is_addi | is_slti | is_lw | is_sw;

  wire [4:0]  dest = is_r ? rd : rt;
  wire [31:0] opb  = is_r ? b_q : simm;
  wire        lt   = $signed(a_q) < $signed(opb);

  logic [31:0] alu_y;
  always_comb begin
    alu_y = a_q + opb;
    if (is_slti) alu_y = {31'd0, lt};
    else if (is_r) begin
      case (funct)
        6'h22:   alu_y = a_q - opb;
        6'h24:   alu_y = a_q & opb;
        6'h25:   alu_y = a_q | opb;
        6'h2A:   alu_y = {31'd0, lt};
        default: alu_y = a_q + opb;
      endcase
    end
  end

  assign instr_done   = (stage == S_ID && !legal) || (stage == S_MEM && is_sw) || (stage == S_WB);
  assign pc_out       = pc;
  assign stage_out    = stage;
  assign rf_peek_data = rf[rf_peek_addr];
  assign dm_peek_data = dmem[dm_peek_idx];

  always_ff @(posedge clk) begin
    if (imem_load_en) imem[imem_load_idx] <= imem_load_data;
  end

  always_ff @(posedge clk) begin
    if (dmem_load_en) dmem[dmem_load_idx] <= dmem_load_data;
    else if (!rst && stage == S_MEM && is_sw) dmem[alu_q[DAW+1:2]] <= b_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      stage <= S_IF;
      ir    <= '0;
      a_q   <= '0;
      b_q   <= '0;
      alu_q <= '0;
      mdr_q <= '0;
      for (int i = 0; i < 32; i++) rf[i] <= '0;
    end else begin
      case (stage)
        S_IF: begin
          ir    <= imem[pc[IAW+1:2]];
          pc    <= pc + 32'd4;
          stage <= S_ID;
        end
        S_ID: begin
          a_q <= rf[rs];
          b_q <= rf[rt];
          if (is_j) pc <= {pc[31:28], ir[25:0], 2'b00};
          stage <= legal ? S_EX : S_IF;
        end
        S_EX: begin
          alu_q <= alu_y;
          stage <= (is_lw || is_sw) ? S_MEM : S_WB;
        end
        S_MEM: begin
          if (is_lw) mdr_q <= dmem[alu_q[DAW+1:2]];
          stage <= is_sw ? S_IF : S_WB;
        end
        S_WB: begin
          if (dest != 5'd0) rf[dest] <= is_lw ? mdr_q : alu_q;
          stage <= S_IF;
        end
        default: stage <= S_IF;
      endcase
    end
  end

  a_r1_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
    stage == S_IF |=> stage == S_ID);
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    stage == S_IF |=> pc == $past(pc) + 32'd4);
  a_r7_skip_memory: assert property (@(posedge clk) disable iff (rst)
    (stage == S_EX && !is_lw && !is_sw) |=> stage == S_WB);
  a_r6_store_no_writeback: assert property (@(posedge clk) disable iff (rst)
    (stage == S_MEM && is_sw) |=> stage == S_IF);
  a_r8_jump_target: assert property (@(posedge clk) disable iff (rst)
    (stage == S_ID && is_j) |=> (pc[27:0] == {$past(ir[25:0]), 2'b00} && pc[1:0] == 2'b00));
  a_r10_done_then_fetch: assert property (@(posedge clk) disable iff (rst)
    instr_done |=> stage_out == 3'd0);
  a_r9_zero_reg: assert property (@(posedge clk) disable iff (rst)
    rf_peek_addr == 5'd0 |-> rf_peek_data == 32'd0);
endmodule

// File: tb/stage_skip_cpu_test.sv
module stage_skip_cpu_test;
  localparam int CLK_PERIOD = 10;
  localparam int NRAND = 180;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imem_load_en = 1'b0, dmem_load_en = 1'b0;
  logic [7:0]  imem_load_idx = '0;
  logic [5:0]  dmem_load_idx = '0, dm_peek_idx = '0;
  logic [31:0] imem_load_data = '0, dmem_load_data = '0;
  logic [4:0]  rf_peek_addr = '0;
  logic [31:0] rf_peek_data, dm_peek_data, pc_out;
  logic [2:0]  stage_out;
  logic        instr_done;

  stage_skip_cpu uut (
    .clk(clk), .rst(rst),
    .imem_load_en(imem_load_en), .imem_load_idx(imem_load_idx), .imem_load_data(imem_load_data),
    .dmem_load_en(dmem_load_en), .dmem_load_idx(dmem_load_idx), .dmem_load_data(dmem_load_data),
    .rf_peek_addr(rf_peek_addr), .rf_peek_data(rf_peek_data),
    .dm_peek_idx(dm_peek_idx), .dm_peek_data(dm_peek_data),
    .pc_out(pc_out), .stage_out(stage_out), .instr_done(instr_done));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, total_cyc = 0;
  bit finished = 0;
  logic [31:0] prog [256];
  logic [31:0] m_rf [32];
  logic [31:0] m_dm [64];
  logic [31:0] m_pc;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  task automatic model_step(output int ecyc, output string ctag, output int wreg,
                            output int widx, output string vtag);
    logic [31:0] w, a, b, si, nxt, ea;
    w = prog[m_pc[9:2]];
    a = m_rf[w[25:21]];
    b = m_rf[w[20:16]];
    si = {{16{w[15]}}, w[15:0]};
    nxt = m_pc + 32'd4;
    ea = a + si;
    ecyc = 2; ctag = "R12 R10"; wreg = -1; widx = -1; vtag = "R12";
    case (w[31:26])
      6'h00: begin
        ecyc = 4; ctag = "R7 R10"; vtag = "R3"; wreg = int'(w[15:11]);
        case (w[5:0])
          6'h20: if (w[15:11] != 0) m_rf[w[15:11]] = a + b;
          6'h22: if (w[15:11] != 0) m_rf[w[15:11]] = a - b;
          6'h24: if (w[15:11] != 0) m_rf[w[15:11]] = a & b;
          6'h25: if (w[15:11] != 0) m_rf[w[15:11]] = a | b;
          6'h2A: if (w[15:11] != 0) m_rf[w[15:11]] = ($signed(a) < $signed(b)) ? 1 : 0;
          default: begin ecyc = 2; ctag = "R12 R10"; vtag = "R12"; wreg = 1; end
        endcase
      end
      6'h08: begin ecyc = 4; ctag = "R7 R10"; vtag = "R4"; wreg = int'(w[20:16]);
        if (w[20:16] != 0) m_rf[w[20:16]] = a + si; end
      6'h0A: begin ecyc = 4; ctag = "R7 R10"; vtag = "R4"; wreg = int'(w[20:16]);
        if (w[20:16] != 0) m_rf[w[20:16]] = ($signed(a) < $signed(si)) ? 1 : 0; end
      6'h23: begin ecyc = 5; ctag = "R5 R10"; vtag = "R5"; wreg = int'(w[20:16]);
        if (w[20:16] != 0) m_rf[w[20:16]] = m_dm[ea[7:2]]; end
      6'h2B: begin ecyc = 4; ctag = "R6 R10"; vtag = "R6"; widx = int'(ea[7:2]);
        m_dm[ea[7:2]] = b; end
      6'h02: begin ecyc = 2; ctag = "R8 R10"; nxt = {nxt[31:28], w[25:0], 2'b00}; end
      default: wreg = 1;
    endcase
    if (wreg == 0) vtag = "R9";
    m_pc = nxt;
  endtask

  always @(posedge clk) begin
    total_cyc++;
    if (total_cyc > 100000 && !finished) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=%0d expected=<100000", total_cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int p;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) prog[i] = 32'd0;
    for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
    for (int i = 0; i < 64; i++) m_dm[i] = $urandom;
    prog[0]  = enc_i(6'h08, 0, 1, 16'hFFFB);
    prog[1]  = enc_i(6'h08, 0, 2, 16'd3);
    prog[2]  = enc_r(1, 2, 3, 6'h2A);
    prog[3]  = enc_i(6'h0A, 2, 4, 16'hFFFF);
    prog[4]  = enc_i(6'h0A, 1, 5, 16'hFFFC);
    prog[5]  = enc_r(2, 1, 6, 6'h22);
    prog[6]  = enc_i(6'h08, 0, 0, 16'd7);
    prog[7]  = enc_i(6'h08, 0, 7, 16'd64);
    prog[8]  = enc_i(6'h2B, 7, 6, 16'hFFF8);
    prog[9]  = enc_i(6'h23, 7, 8, 16'hFFF8);
    prog[10] = 32'hFC00_0000;
    prog[11] = {6'h02, 26'd14};
    prog[12] = enc_i(6'h08, 0, 9, 16'd99);
    prog[13] = enc_i(6'h08, 0, 9, 16'd99);
    p = 14;
    for (int i = 0; i < NRAND; i++) begin
      int k, rs, rt, rd;
      logic [15:0] imm;
      k = $urandom_range(0, 8); rs = $urandom_range(0, 7);
      rt = $urandom_range(0, 7); rd = $urandom_range(0, 7);
      imm = 16'($urandom_range(0, 65535));
      case (k)
        0: prog[p] = enc_r(rs, rt, rd, 6'h20);
        1: prog[p] = enc_r(rs, rt, rd, 6'h22);
        2: prog[p] = enc_r(rs, rt, rd, 6'h24);
        3: prog[p] = enc_r(rs, rt, rd, 6'h25);
        4: prog[p] = enc_r(rs, rt, rd, 6'h2A);
        5: prog[p] = enc_i(6'h08, rs, rt, imm);
        6: prog[p] = enc_i(6'h0A, rs, rt, imm);
        7: prog[p] = enc_i(6'h23, 0, rt, 16'($urandom_range(0, 63) * 4));
        default: prog[p] = enc_i(6'h2B, 0, rt, 16'($urandom_range(0, 63) * 4));
      endcase
      p++;
    end

    @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      imem_load_en = 1; imem_load_idx = 8'(i); imem_load_data = prog[i];
      @(negedge clk);
    end
    imem_load_en = 0;
    for (int i = 0; i < 64; i++) begin
      dmem_load_en = 1; dmem_load_idx = 6'(i); dmem_load_data = m_dm[i];
      @(negedge clk);
    end
    dmem_load_en = 0;

    rf_peek_addr = 5'd5; #1;
    check(pc_out == 0, "R11 pc", pc_out, 0);
    check(stage_out == 3'd0, "R11 stage", {29'd0, stage_out}, 0);
    check(rf_peek_data == 0, "R11 reg", rf_peek_data, 0);
    @(negedge clk);
    rst = 0;
    m_pc = 0;

    for (int n = 0; n < 12 + NRAND; n++) begin
      int ecyc, cyc, wreg, widx;
      string ctag, vtag;
      model_step(ecyc, ctag, wreg, widx, vtag);
      cyc = 1;
      while (!instr_done && cyc < 12) begin @(negedge clk); cyc++; end
      check(cyc == ecyc, ctag, cyc, ecyc);
      @(negedge clk);
      check(stage_out == 3'd0, "R1 R10 fetch after done", {29'd0, stage_out}, 0);
      check(pc_out == m_pc, (ctag == "R8 R10") ? "R8 pc" : "R2 pc", pc_out, m_pc);
      if (wreg >= 0) begin
        rf_peek_addr = 5'(wreg); #1;
        check(rf_peek_data == m_rf[wreg], vtag, rf_peek_data, m_rf[wreg]);
      end
      if (widx >= 0) begin
        dm_peek_idx = 6'(widx); #1;
        check(dm_peek_data == m_dm[widx], "R6 store", dm_peek_data, m_dm[widx]);
      end
    end

    for (int i = 0; i < 32; i++) begin
      rf_peek_addr = 5'(i); #1;
      check(rf_peek_data == m_rf[i], "R3 final register sweep", rf_peek_data, m_rf[i]);
    end
    for (int i = 0; i < 64; i++) begin
      dm_peek_idx = 6'(i); #1;
      check(dm_peek_data == m_dm[i], "R6 final memory sweep", dm_peek_data, m_dm[i]);
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule